// File: doc/BRIEF.md
# Tomasulo Floating-Point Issue Scheduler

This block is a dynamic scheduler for floating-point work. It has reservation stations, a register status table and one shared result bus, and it has no reorder buffer. Each cycle it can accept one decoded instruction: load, store, FP add or FP multiply. It renames source operands through the register status table. Operations wait in stations, each named by a tag, until both operands are present. Each operation then runs for the fixed latency of its class, and its result is broadcast to the register file and to every station that is waiting for that tag. The datapaths are behavioural placeholders: a load returns its own effective address, an add returns the sum and a multiply returns the low half of the product.

For checking, every finished instruction comes out once on a completion port. The port gives four cycle stamps: issue, execute start, execute end and write-back. The cycle counter reads 1 in the first cycle after reset is released. A single read port gives access to the architectural register file and to the pending flag of each register.

Top module: `tomasulo_sched`

## Requirements
- R1: After reset, `in_ready` is high, nothing completes, every register Fn reads the value n and no register is pending.
- R2: Op codes are 0 = load, 1 = store, 2 = FP add and 3 = FP multiply.
  - An instruction issues in a cycle where `in_valid` and `in_ready` are both high, and at most one issues per cycle.
  - `in_ready` is low while every station of the needed class is busy. There are three load/store buffers with tags 1 to 3, three add stations with tags 4 to 6 and two multiply stations with tags 7 and 8.
  - An instruction takes the lowest free station of its class.
- R3: A load executes for two cycles, starting the cycle after issue. It broadcasts in the cycle after execution ends, with value `in_base + in_imm`. A load issued in cycle 1 therefore has the stamps 1, 2, 3, 4.
- R4: An FP add executes for 2 cycles and produces a+b. An FP multiply executes for 4 cycles and produces the low 16 bits of a*b. Both broadcast at the earliest in the cycle after execution ends.
- R5: A source operand is handled as follows:
  - If its register is not pending, the operand copies the register value.
  - If its register is pending, the operand records the producer's tag and captures the value from the result bus.
  - A value broadcast in the issue cycle itself is taken at once.
  - Execution starts in the cycle after the last operand is captured.
- R6: At most one instruction completes per cycle. When several have finished, the one issued earliest completes and the others retry in later cycles.
- R7: A store waits for its data operand and executes for 2 cycles. In its completion cycle it drives `mem_wr_valid` with address `in_base + in_imm`, and it never drives the result bus.
- R8: A broadcast writes a register only while that register's status still names the broadcasting tag, and the write clears the pending flag. An older producer whose destination was renamed again leaves the register unchanged.
- R9: A station is released in its completion cycle, so an instruction stalled on it can issue in the next cycle.
- R10: In each completion, issue < execute start <= execute end < write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered this cycle |
| in_op | input | 2 | Op code (0 load, 1 store, 2 add, 3 mul) |
| in_dst | input | 4 | Destination FP register (not used by stores) |
| in_src1 | input | 4 | First source register (data register for a store) |
| in_src2 | input | 4 | Second source register (add and mul only) |
| in_base | input | 16 | Base address value for load and store |
| in_imm | input | 16 | Immediate offset for load and store |
| in_ready | output | 1 | A station of the offered class is free |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | 4 | Tag of the broadcasting station |
| cdb_value | output | 16 | Broadcast value |
| mem_wr_valid | output | 1 | Store writes memory this cycle |
| mem_wr_addr | output | 16 | Store address |
| mem_wr_data | output | 16 | Store data |
| done_valid | output | 1 | An instruction completes this cycle |
| done_issue | output | 16 | Issue cycle stamp |
| done_start | output | 16 | Execute-start cycle stamp |
| done_end | output | 16 | Execute-end cycle stamp |
| done_wb | output | 16 | Write-back cycle stamp (the current cycle) |
| rf_idx | input | 4 | Register file read index |
| rf_value | output | 16 | Architectural value of register `rf_idx` |
| rf_busy | output | 1 | Register `rf_idx` waits for a producer |

## Verification
Each kind of wrong internal state shows up at the ports in its own way:

- **Stale register status.** The next consumer picks up an old value or waits on the wrong tag. This shows as a wrong broadcast value or a late execute-start stamp, within a few cycles of the offending issue.
- **Lost result-bus capture.** The waiting station never starts. Its completion is missing, so the scoreboard queue never empties.
- **Wrong arbitration or a wrong release.** Write-back stamps move by a cycle, or `in_ready` stays low one cycle too long.
- **WAW error.** The final register value after a renamed destination is wrong when read back through the register port.

// File: rtl/tomasulo_pkg.sv
package tomasulo_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_ADD   = 2'd2,
        OP_MUL   = 2'd3
    } op_e;

    localparam int LAT_MEM = 2;
    localparam int LAT_ADD = 2;
    localparam int LAT_MUL = 4;
    localparam int LAT_W   = 3;

    function automatic logic [LAT_W-1:0] op_latency(op_e op);
        case (op)
            OP_ADD:  return LAT_W'(LAT_ADD);
            OP_MUL:  return LAT_W'(LAT_MUL);
            default: return LAT_W'(LAT_MEM);
        endcase
    endfunction
endpackage

// File: rtl/oldest_pick.sv
module oldest_pick #(
    parameter int N     = 8,
    parameter int AGE_W = 16
) (
    input  logic [N-1:0]       req,
    input  logic [N*AGE_W-1:0] age,
    output logic [N-1:0]       gnt,
    output logic               any
);
    logic [AGE_W-1:0] best;

    always_comb begin
        gnt  = '0;
        any  = 1'b0;
        best = '1;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!any || age[i*AGE_W +: AGE_W] < best)) begin
                any    = 1'b1;
                best   = age[i*AGE_W +: AGE_W];
                gnt    = '0;
                gnt[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tomasulo_sched.sv
module tomasulo_sched
    import tomasulo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_N  = 16,
    parameter int LS_N   = 3,
    parameter int ADD_N  = 3,
    parameter int MUL_N  = 2,
    parameter int CYC_W  = 16,
    parameter int REG_W  = $clog2(REG_N),
    parameter int TAG_W  = $clog2(LS_N + ADD_N + MUL_N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [REG_W-1:0]  in_dst,
    input  logic [REG_W-1:0]  in_src1,
    input  logic [REG_W-1:0]  in_src2,
    input  logic [DATA_W-1:0] in_base,
    input  logic [DATA_W-1:0] in_imm,
    output logic              in_ready,
    output logic              cdb_valid,
    output logic [TAG_W-1:0]  cdb_tag,
    output logic [DATA_W-1:0] cdb_value,
    output logic              mem_wr_valid,
    output logic [DATA_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              done_valid,
    output logic [CYC_W-1:0]  done_issue,
    output logic [CYC_W-1:0]  done_start,
    output logic [CYC_W-1:0]  done_end,
    output logic [CYC_W-1:0]  done_wb,
    input  logic [REG_W-1:0]  rf_idx,
    output logic [DATA_W-1:0] rf_value,
    output logic              rf_busy
);
    localparam int RS_N     = LS_N + ADD_N + MUL_N;
    localparam int ADD_BASE = LS_N;
    localparam int MUL_BASE = LS_N + ADD_N;

    typedef struct packed {
        logic              busy;
        op_e               op;
        logic [DATA_W-1:0] vj;
        logic [DATA_W-1:0] vk;
        logic [TAG_W-1:0]  qj;
        logic [TAG_W-1:0]  qk;
        logic [DATA_W-1:0] addr;
        logic              started;
        logic              fin;
        logic [LAT_W-1:0]  rem;
        logic [DATA_W-1:0] res;
        logic [CYC_W-1:0]  t_iss;
        logic [CYC_W-1:0]  t_st;
        logic [CYC_W-1:0]  t_end;
    } rs_t;

    typedef struct packed {
        rs_t [RS_N-1:0]                    rs;
        logic [REG_N-1:0][DATA_W-1:0]      rf;
        logic [REG_N-1:0][TAG_W-1:0]       stat;
        logic [CYC_W-1:0]                  cyc;
    } state_t;

    state_t s_q, s_d;

    // completion arbitration
    logic [RS_N-1:0]       req_vec, gnt_vec, busy_vec;
    logic [RS_N*CYC_W-1:0] age_vec;
    logic                  win_any;
    rs_t                   win_rs;
    logic [TAG_W-1:0]      win_tag;

    always_comb begin
        for (int i = 0; i < RS_N; i++) begin
            busy_vec[i]                 = s_q.rs[i].busy;
            req_vec[i]                  = s_q.rs[i].busy && s_q.rs[i].fin;
            age_vec[i*CYC_W +: CYC_W]   = s_q.rs[i].t_iss;
        end
    end

    oldest_pick #(.N(RS_N), .AGE_W(CYC_W)) u_pick (
        .req(req_vec), .age(age_vec), .gnt(gnt_vec), .any(win_any)
    );

    always_comb begin
        win_rs  = '0;
        win_tag = '0;
        for (int i = 0; i < RS_N; i++) begin
            if (gnt_vec[i]) begin
                win_rs  = s_q.rs[i];
                win_tag = TAG_W'(i + 1);
            end
        end
    end

    assign done_valid   = win_any;
    assign done_issue   = win_rs.t_iss;
    assign done_start   = win_rs.t_st;
    assign done_end     = win_rs.t_end;
    assign done_wb      = s_q.cyc;
    assign cdb_valid    = win_any && (win_rs.op != OP_STORE);
    assign cdb_tag      = win_tag;
    assign cdb_value    = win_rs.res;
    assign mem_wr_valid = win_any && (win_rs.op == OP_STORE);
    assign mem_wr_addr  = win_rs.addr;
    assign mem_wr_data  = win_rs.res;
    assign rf_value     = s_q.rf[rf_idx];
    assign rf_busy      = s_q.stat[rf_idx] != '0;

    // free station search for the offered class
    op_e             new_op;
    logic [RS_N-1:0] free_oh;
    assign new_op = op_e'(in_op);

    always_comb begin
        free_oh  = '0;
        in_ready = 1'b0;
        for (int i = 0; i < RS_N; i++) begin
            logic cls;
            cls = (i < ADD_BASE) ? (new_op == OP_LOAD || new_op == OP_STORE) :
                  (i < MUL_BASE) ? (new_op == OP_ADD) : (new_op == OP_MUL);
            if (cls && !s_q.rs[i].busy && !in_ready) begin
                in_ready   = 1'b1;
                free_oh[i] = 1'b1;
            end
        end
    end

    // source operand lookup, including same-cycle bus capture
    logic [DATA_W-1:0] op1_v, op2_v;
    logic [TAG_W-1:0]  op1_q, op2_q;

    always_comb begin
        op1_q = s_q.stat[in_src1];
        op1_v = s_q.rf[in_src1];
        if (op1_q != '0 && cdb_valid && op1_q == cdb_tag) begin
            op1_q = '0;
            op1_v = cdb_value;
        end
        op2_q = s_q.stat[in_src2];
        op2_v = s_q.rf[in_src2];
        if (op2_q != '0 && cdb_valid && op2_q == cdb_tag) begin
            op2_q = '0;
            op2_v = cdb_value;
        end
    end

    // next-state computation
    always_comb begin
        s_d     = s_q;
        s_d.cyc = s_q.cyc + 1'b1;
        for (int i = 0; i < RS_N; i++) begin
            rs_t r;
            logic [LAT_W-1:0] rem_eff;
            r       = s_q.rs[i];
            rem_eff = r.started ? r.rem : op_latency(r.op);
            if (r.busy && !r.fin && (r.started || (r.qj == '0 && r.qk == '0))) begin
                if (!r.started) r.t_st = s_q.cyc;
                r.started = 1'b1;
                if (rem_eff == LAT_W'(1)) begin
                    r.fin   = 1'b1;
                    r.t_end = s_q.cyc;
                    case (r.op)
                        OP_LOAD: r.res = r.addr;
                        OP_ADD:  r.res = r.vj + r.vk;
                        OP_MUL:  r.res = r.vj * r.vk;
                        default: r.res = r.vj;
                    endcase
                end else begin
                    r.rem = rem_eff - LAT_W'(1);
                end
            end
            if (cdb_valid && r.busy && r.qj == cdb_tag) begin
                r.vj = cdb_value;
                r.qj = '0;
            end
            if (cdb_valid && r.busy && r.qk == cdb_tag) begin
                r.vk = cdb_value;
                r.qk = '0;
            end
            if (gnt_vec[i]) r.busy = 1'b0;
            if (in_valid && free_oh[i]) begin
                r         = '0;
                r.busy    = 1'b1;
                r.op      = new_op;
                r.addr    = in_base + in_imm;
                r.t_iss   = s_q.cyc;
                if (new_op != OP_LOAD) begin
                    r.vj = op1_v;
                    r.qj = op1_q;
                end
                if (new_op == OP_ADD || new_op == OP_MUL) begin
                    r.vk = op2_v;
                    r.qk = op2_q;
                end
            end
            s_d.rs[i] = r;
        end
        if (cdb_valid) begin
            for (int g = 0; g < REG_N; g++) begin
                if (s_q.stat[g] == cdb_tag) begin
                    s_d.rf[g]   = cdb_value;
                    s_d.stat[g] = '0;
                end
            end
        end
        if (in_valid && in_ready && new_op != OP_STORE) begin
            for (int i = 0; i < RS_N; i++) begin
                if (free_oh[i]) s_d.stat[in_dst] = TAG_W'(i + 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cyc <= CYC_W'(1);
            for (int g = 0; g < REG_N; g++) s_q.rf[g] <= DATA_W'(g);
        end else begin
            s_q <= s_d;
        end
    end

    // R2
    stall_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> ($countones(busy_vec) <= $past($countones(busy_vec))));

    // R6
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_vec) && ((gnt_vec & ~req_vec) == '0));

    // R10
    stamp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_issue < done_start && done_start <= done_end && done_end < done_wb));

    // R7
    store_off_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> !cdb_valid);

    generate
        for (genvar k = 0; k < RS_N; k++) begin : g_rel
            // R9
            release_chk: assert property (@(posedge clk) disable iff (!rst_n)
                gnt_vec[k] |=> !busy_vec[k]);
        end
    endgenerate
endmodule

// File: tb/tomasulo_sched_test.sv
module tomasulo_sched_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_valid = 0;
    logic [1:0]  in_op = 0;
    logic [3:0]  in_dst = 0, in_src1 = 0, in_src2 = 0, rf_idx = 0;
    logic [15:0] in_base = 0, in_imm = 0;
    logic        in_ready, cdb_valid, mem_wr_valid, done_valid, rf_busy;
    logic [3:0]  cdb_tag;
    logic [15:0] cdb_value, mem_wr_addr, mem_wr_data, rf_value;
    logic [15:0] done_issue, done_start, done_end, done_wb;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        int    iss, st, en, wb;
        bit    store;
        int    val, addr, tag;
        string req;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tomasulo_sched uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .in_base(in_base), .in_imm(in_imm), .in_ready(in_ready),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .done_valid(done_valid), .done_issue(done_issue), .done_start(done_start),
        .done_end(done_end), .done_wb(done_wb),
        .rf_idx(rf_idx), .rf_value(rf_value), .rf_busy(rf_busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input string req, input int iss, st, en, wb, input bit store,
                        input int val, addr, tag);
        exp_t e;
        e.iss = iss; e.st = st; e.en = en; e.wb = wb; e.store = store;
        e.val = val; e.addr = addr; e.tag = tag; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: pop and compare each completion
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && done_valid) begin
                if (sb.size() == 0) begin
                    chk("R6", "unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk("R10", "issue stamp", int'(done_issue), e.iss);
                    chk(e.req, "start stamp", int'(done_start), e.st);
                    chk(e.req, "end stamp", int'(done_end), e.en);
                    chk("R6", "write-back stamp", int'(done_wb), e.wb);
                    if (e.store) begin
                        chk("R7", "store off bus", int'(cdb_valid), 0);
                        chk("R7", "store write", int'(mem_wr_valid), 1);
                        chk("R7", "store addr", int'(mem_wr_addr), e.addr);
                        chk("R7", "store data", int'(mem_wr_data), e.val);
                    end else begin
                        chk(e.req, "bus valid", int'(cdb_valid), 1);
                        chk(e.req, "bus value", int'(cdb_value), e.val);
                        chk("R2", "bus tag", int'(cdb_tag), e.tag);
                    end
                end
            end
        end
    end

    task automatic do_reset();
        in_valid = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic issue(input int op, dst, s1, s2, base, imm, output int stalls);
        stalls = 0;
        in_valid = 1; in_op = 2'(op); in_dst = 4'(dst); in_src1 = 4'(s1);
        in_src2 = 4'(s2); in_base = 16'(base); in_imm = 16'(imm);
        #1;
        while (!in_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic drain(input string req);
        int n = 0;
        while (sb.size() != 0 && n < 100) begin
            @(negedge clk);
            n++;
        end
        #3;
        chk(req, "all completions seen", sb.size(), 0);
    endtask

    task automatic rf_chk(input string req, input int idx, input int val, input int busy);
        rf_idx = 4'(idx);
        #1;
        chk(req, "rf value", int'(rf_value), val);
        chk(req, "rf pending", int'(rf_busy), busy);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int st;
        bit rf_ok;

        // R1 reset state
        do_reset();
        #1;
        chk("R1", "ready after reset", int'(in_ready), 1);
        chk("R1", "no completion", int'(done_valid), 0);
        rf_ok = 1;
        for (int r = 0; r < 16; r++) begin
            rf_idx = 4'(r);
            #1;
            if (rf_value != 16'(r) || rf_busy) rf_ok = 0;
        end
        chk("R1", "rf holds index, none pending", int'(rf_ok), 1);

        // Program with RAW, WAR and WAW hazards (R3 R4 R5 R7 R8)
        do_reset();
        push("R3", 1, 2, 3, 4, 0, 108, 0, 1);
        push("R3", 2, 3, 4, 5, 0, 208, 0, 2);
        push("R5", 5, 6, 7, 8, 0, 316, 0, 4);
        push("R4", 3, 6, 9, 10, 0, 22464, 0, 7);
        push("R5", 6, 9, 10, 11, 0, 322, 0, 5);
        push("R7", 4, 11, 12, 13, 1, 22464, 208, 0);
        issue(0, 1, 0, 0, 100, 8, st);
        issue(0, 2, 0, 0, 200, 8, st);
        issue(3, 4, 1, 2, 0, 0, st);
        issue(1, 0, 4, 0, 200, 8, st);
        issue(2, 4, 1, 2, 0, 0, st);
        issue(2, 6, 6, 4, 0, 0, st);
        rf_chk("R8", 6, 6, 1);
        drain("R5");
        rf_chk("R8", 4, 316, 0);
        rf_chk("R8", 6, 322, 0);
        rf_chk("R3", 1, 108, 0);

        // Station exhaustion and release (R2 R9)
        do_reset();
        push("R3", 1, 2, 3, 4, 0, 11, 0, 1);
        push("R3", 2, 3, 4, 5, 0, 22, 0, 2);
        push("R3", 3, 4, 5, 6, 0, 33, 0, 3);
        push("R9", 5, 6, 7, 8, 0, 44, 0, 1);
        issue(0, 1, 0, 0, 10, 1, st);
        issue(0, 2, 0, 0, 20, 2, st);
        issue(0, 3, 0, 0, 30, 3, st);
        issue(0, 4, 0, 0, 40, 4, st);
        chk("R2", "stall cycles for fourth load", st, 1);
        drain("R9");

        // Result-bus contention: oldest first (R6)
        do_reset();
        push("R4", 1, 2, 5, 6, 0, 15, 0, 7);
        push("R6", 3, 4, 5, 7, 0, 13, 0, 4);
        issue(3, 9, 3, 5, 0, 0, st);
        @(negedge clk);
        issue(2, 10, 6, 7, 0, 0, st);
        drain("R6");
        rf_chk("R4", 9, 15, 0);
        rf_chk("R4", 10, 13, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule